// File: doc/BRIEF.md
# Modulo-Five Event Tally

This block tallies pulses that arrive on one event line and presents the running total in two parts. The first part is the remainder of the total after division by five. The second part is the quotient of that division. The event line rests at 0 and may pulse at steady or uneven intervals. Each pulse is recognised once, on its rising edge, so a level that stays high over many clocks adds exactly one to the total.

Internally two counters are chained. The remainder counter steps through 0 to 4. The event that finds it at 4 returns it to 0, and in the same clock the quotient counter advances. A synchronous init input clears both results together and takes precedence over an event. The quotient width is a parameter. At its default of 4 bits the quotient rolls over from 15 to 0 and raises no flag.

Top module: `quin_tally`

## Requirements
- R1: The remainder output only ever holds a value from 0 to 4. Each recognised event below 4 raises it by exactly one.
- R2: An event recognised while the remainder is 4 sets the remainder to 0 and raises the quotient by one at the same clock edge.
- R3: The quotient changes only on an event recognised while the remainder is 4, or on init or reset.
- R4: The quotient is QUO_W bits wide (4 by default). From its largest value (15) it rolls over to 0 on the next qualifying event, and no other output reacts.
- R5: Init high at a rising clock edge sets both remainder and quotient to 0 at that edge.
- R6: When init is high at the edge where an event would be counted, that event is dropped and both outputs read 0.
- R7: A high level on the event input counts once however long it lasts. A further count needs the input to return to 0 for at least one clock.
- R8: The event input is registered before edge detection. A rise first seen at clock edge k changes the outputs at edge k+1.
- R9: rst_n low forces both outputs to 0 at once. Its release takes effect through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Reset, active low, asserted asynchronously, released synchronously |
| init | input | 1 | Synchronous clear of both results |
| evt | input | 1 | Event line, idles low, one count per rising edge |
| rem | output | 3 | Total modulo 5 |
| quo | output | QUO_W (4) | Total divided by 5, rolls over |

## Verification
A wrong remainder state shows at once on rem, and the quotient goes wrong at the next multiple of five: a missed wrap leaves rem at 5 or above, and an early wrap advances quo too soon. The bench therefore checks both outputs together after each event, including the count that carries into the quotient and the count that rolls the quotient over. A fault in the edge detector shows as extra counts from long pulses, or as the result landing one cycle early or late, and the bench samples the exact cycle to catch it. A broken init priority leaves rem at 1 after a collision.

// File: rtl/quin_pkg.sv
package quin_pkg;

  // Default divisor of the tally.
  localparam int unsigned DIVISOR_DEF = 5;

  // Bits needed to hold values 0 .. n-1, at least one.
  function automatic int unsigned span_bits(input int unsigned n);
    int unsigned w;
    w = (n <= 2) ? 1 : $clog2(n);
    return w;
  endfunction

endpackage

// File: rtl/quin_rst_sync.sv
module quin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/quin_rise.sv
module quin_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);

  logic lvl_q;
  logic lvl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      lvl_prev_q <= 1'b0;
    end else begin
      lvl_q      <= level;
      lvl_prev_q <= lvl_q;
    end
  end

  assign rise = lvl_q & ~lvl_prev_q;

  // A detected rise never lasts two cycles.
  AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R7

endmodule

// File: rtl/quin_digit.sv
module quin_digit #(
  parameter int unsigned W    = 3,
  parameter int unsigned LAST = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         at_last
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_nxt;
  logic         val_en;

  assign at_last = (val_q == W'(LAST));

  always_comb begin
    val_en  = clr | inc;
    val_nxt = val_q;
    if (clr) begin
      val_nxt = '0;
    end else if (inc) begin
      val_nxt = at_last ? '0 : val_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_nxt;
    end
  end

  assign val = val_q;

  AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && at_last && !clr) |=> (val == '0)); // R2

  AST_DIGIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (val == '0)); // R5

  AST_DIGIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(val)); // R3

endmodule

// File: rtl/quin_tally.sv
module quin_tally #(
  parameter int unsigned DIVISOR = quin_pkg::DIVISOR_DEF,
  parameter int unsigned QUO_W   = 4,
  localparam int unsigned REM_W  = quin_pkg::span_bits(DIVISOR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             evt,
  output logic [REM_W-1:0] rem,
  output logic [QUO_W-1:0] quo
);

  localparam int unsigned REM_LAST = DIVISOR - 1;
  localparam int unsigned QUO_LAST = (1 << QUO_W) - 1;

  logic rst_sync_n;
  logic tick;
  logic rem_last;
  logic quo_last;
  logic carry;

  quin_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  quin_rise rise_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .level (evt),
    .rise  (tick)
  );

  assign carry = tick & rem_last;

  quin_digit #(.W(REM_W), .LAST(REM_LAST)) rem_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (init),
    .inc     (tick),
    .val     (rem),
    .at_last (rem_last)
  );

  quin_digit #(.W(QUO_W), .LAST(QUO_LAST)) quo_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (init),
    .inc     (carry),
    .val     (quo),
    .at_last (quo_last)
  );

  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rem <= REM_W'(REM_LAST)); // R1

  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!init && tick && !rem_last) |=> (rem == $past(rem) + REM_W'(1))); // R1

  AST_QUO_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!init && tick && rem_last) |=> (quo == QUO_W'($past(quo) + QUO_W'(1)) && rem == '0)); // R2

  AST_QUO_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!init && !(tick && rem_last)) |=> $stable(quo)); // R3

  AST_QUO_ROLL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!init && tick && rem_last && quo_last) |=> (quo == '0)); // R4

  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init && tick) |=> (rem == '0 && quo == '0)); // R6

endmodule

// File: tb/quin_tally_tb.sv
`timescale 1ns/1ps
module quin_tally_tb_top;

  logic       clk;
  logic       rst_n;
  logic       init;
  logic       evt;
  logic [2:0] rem;
  logic [3:0] quo;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  quin_tally dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (init),
    .evt   (evt),
    .rem   (rem),
    .quo   (quo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Fields: high cycles, low cycles, expected rem, expected quo.
  localparam logic [15:0] VEC [10] = '{
    16'h1_2_1_0, 16'h3_2_2_0, 16'h1_3_3_0, 16'h5_2_4_0, 16'h1_2_0_1,
    16'h2_4_1_1, 16'h1_2_2_1, 16'h7_2_3_1, 16'h1_5_4_1, 16'h2_2_0_2
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    evt = 1'b1;
    repeat (hi) @(negedge clk);
    evt = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    init  = 1'b0;
    evt   = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 rem in reset", int'(rem), 0);
    check("R9 quo in reset", int'(quo), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: R1 R2 R7 under varied spacing and widths.
    for (int i = 0; i < 10; i++) begin
      pulse(int'(VEC[i][15:12]), int'(VEC[i][11:8]));
      check($sformatf("R1 R2 R7 rem vec %0d", i), int'(rem), int'(VEC[i][7:4]));
      check($sformatf("R2 R3 quo vec %0d", i), int'(quo), int'(VEC[i][3:0]));
    end

    // R8: result appears one edge after the rise is sampled.
    evt = 1'b1;
    @(negedge clk);
    check("R8 no change after first edge", int'(rem), 0);
    @(negedge clk);
    check("R8 change after second edge", int'(rem), 1);
    evt = 1'b0;
    repeat (2) @(negedge clk);

    // R7: long level counts once.
    pulse(20, 2);
    check("R7 long level counts once", int'(rem), 2);

    // R5: init clears both.
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    check("R5 rem cleared", int'(rem), 0);
    check("R5 quo cleared", int'(quo), 0);

    // R6: init coinciding with the counting edge drops the event.
    evt  = 1'b1;
    init = 1'b1;
    repeat (2) @(negedge clk);
    init = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 event dropped under init", int'(rem), 0);
    evt = 1'b0;
    repeat (2) @(negedge clk);

    // R4: roll-over of the quotient.
    for (int i = 0; i < 75; i++) pulse(1, 1);
    @(negedge clk);
    check("R4 quo at top", int'(quo), 15);
    check("R4 rem at top", int'(rem), 0);
    for (int i = 0; i < 4; i++) pulse(1, 1);
    @(negedge clk);
    check("R3 quo holds below wrap", int'(quo), 15);
    check("R1 rem at four", int'(rem), 4);
    pulse(1, 2);
    check("R4 quo rolls to zero", int'(quo), 0);
    check("R2 rem wraps with roll", int'(rem), 0);

    // R9: asynchronous reset mid-run.
    pulse(1, 2);
    check("R1 rem before reset", int'(rem), 1);
    rst_n = 1'b0;
    #1;
    check("R9 async reset clears rem", int'(rem), 0);
    check("R9 async reset clears quo", int'(quo), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule